// File: doc/BRIEF.md
# Linked Scatter-List Walker

This block walks a chain of 16-byte scatter descriptors held in system memory for one disk DMA transfer. A packet sequencer gives it the byte address of the first descriptor and a start pulse. The walker reads each descriptor as four 32-bit words over a simple request/acknowledge read port. It checks the descriptor, then presents one segment (address, length in 8-byte units, direction, ordering hint and timing mode) to a transfer engine. It holds that request until the engine reports the segment finished.

After a segment finishes, the walker either follows the pointer embedded in the descriptor or, if the descriptor is marked last, reports completion. Malformed chains end the walk with a coded error. Data movement and buffering belong to the transfer engine and are not part of this block.

Top module: `sgw_chain_walker`

## Requirements
- R1: When idle, a `start` pulse with an 8-byte-aligned `start_ptr` raises `busy` on the next cycle. The descriptor is then read as four words at `start_ptr`, +4, +8 and +12, in that order. Each request holds `mrd_addr` steady until `mrd_ack`, and `mrd_data` is taken as little-endian (byte 0 in bits 7:0).
- R2: A segment request carries word 0 as `seg_addr` and word 1 unchanged as `seg_len` (units of 8 bytes). It also carries word 2 bit 5 as `seg_write`, word 2 bit 4 as `seg_order` and word 2 bits 11:8 as `seg_mode`. Word 2 bits 31:16 have no effect. `seg_req` and its fields stay stable until `seg_done`.
- R3: No descriptor read is requested while a segment request is outstanding. The next descriptor is fetched from the word-3 address only after `seg_done`.
- R4: A descriptor with word 2 bit 7 set is the last one. After its `seg_done`, `done` pulses for one cycle, `busy` falls in the same cycle, and its word 3 is never read as a pointer.
- R5: A last descriptor with a zero length completes the chain with `done` and issues no segment for itself.
- R6: A pointer whose low 3 bits are not zero ends the walk with `err` and `err_code` 1. This applies to `start_ptr`, and then no read is made, and to word 3 of a non-last descriptor.
- R7: A zero length on a non-last descriptor ends the walk with `err_code` 2.
- R8: A descriptor whose direction bit differs from that of the chain's first descriptor ends the walk with `err_code` 3.
- R9: A descriptor that fails a check issues no segment. `err` pulses for one cycle with `busy` falling in the same cycle. `err_code` holds its value until the next accepted start. When several checks fail, code 2 wins over 3, and 3 wins over 1.
- R10: A `start` pulse while `busy` is high has no effect on the walk in progress.
- R11: After reset `busy`, `done`, `err`, `mrd_req` and `seg_req` are low and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| start_ptr | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: chain completed |
| err | output | 1 | One-cycle pulse: walk stopped on a fault |
| err_code | output | 2 | Fault code: 1 pointer, 2 zero length, 3 direction |
| mrd_req | output | 1 | Memory read request |
| mrd_addr | output | 32 | Byte address of the word requested |
| mrd_ack | input | 1 | Read response valid |
| mrd_data | input | 32 | Read data, little-endian |
| seg_req | output | 1 | Segment request to the transfer engine |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | 32 | Segment length in 8-byte units |
| seg_write | output | 1 | Direction: 1 toward the device |
| seg_order | output | 1 | Ordering hint for the segment |
| seg_mode | output | 4 | Timing mode for the segment |
| seg_done | input | 1 | Engine finished the segment |

## Verification
A wrong word index or base pointer shows at once on `mrd_addr` during the same fetch, so the bench compares every read address. A corrupted decode shows at the segment port as soon as that descriptor is issued, and each issued segment is compared field by field. A lost direction reference or last flag stays hidden until a later descriptor. It then appears as a spurious or missing error code, an extra read of the garbage word-3 pointer, or a wrong segment count when the walk ends. Chains of one to four entries, in both directions and with scattered placement, cover these within a few dozen cycles per chain.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int unsigned SGW_AW     = 32;
    localparam int unsigned SGW_WORDS  = 4;
    localparam int unsigned SGW_IDX_W  = $clog2(SGW_WORDS);
    localparam int unsigned SGW_MODE_W = 4;

    // flag byte positions inside descriptor word 2
    localparam int unsigned SGW_ORDER_BIT = 4;
    localparam int unsigned SGW_WRITE_BIT = 5;
    localparam int unsigned SGW_LAST_BIT  = 7;
    localparam int unsigned SGW_MODE_LSB  = 8;

    typedef struct packed {
        logic [SGW_AW-1:0]     addr;
        logic [SGW_AW-1:0]     len;
        logic                  write;
        logic                  order;
        logic                  last;
        logic [SGW_MODE_W-1:0] mode;
        logic [SGW_AW-1:0]     next;
    } sgw_desc_t;

    typedef enum logic [1:0] {
        SGW_OK           = 2'd0,
        SGW_BAD_PTR      = 2'd1,
        SGW_ZERO_LEN     = 2'd2,
        SGW_DIR_MISMATCH = 2'd3
    } sgw_fault_e;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_FETCH,
        WS_ISSUE
    } sgw_state_e;

    function automatic sgw_desc_t sgw_decode(input logic [SGW_WORDS*SGW_AW-1:0] raw);
        sgw_desc_t         d;
        logic [SGW_AW-1:0] flags;
        flags   = raw[2*SGW_AW +: SGW_AW];
        d.addr  = raw[0 +: SGW_AW];
        d.len   = raw[SGW_AW +: SGW_AW];
        d.order = flags[SGW_ORDER_BIT];
        d.write = flags[SGW_WRITE_BIT];
        d.last  = flags[SGW_LAST_BIT];
        d.mode  = flags[SGW_MODE_LSB +: SGW_MODE_W];
        d.next  = raw[3*SGW_AW +: SGW_AW];
        return d;
    endfunction

    function automatic logic sgw_aligned(input logic [SGW_AW-1:0] p, input int unsigned bits);
        logic [SGW_AW-1:0] mask;
        mask = (SGW_AW'(1) << bits) - SGW_AW'(1);
        return (p & mask) == '0;
    endfunction

endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
    import sgw_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        go,
    input  logic [SGW_AW-1:0]           base,
    output logic                        mrd_req,
    output logic [SGW_AW-1:0]           mrd_addr,
    input  logic                        mrd_ack,
    input  logic [SGW_AW-1:0]           mrd_data,
    output logic [SGW_WORDS*SGW_AW-1:0] raw,
    output logic                        fin
);

    localparam logic [SGW_IDX_W-1:0] LAST_IDX = SGW_IDX_W'(SGW_WORDS - 1);

    logic                                 active;
    logic [SGW_IDX_W-1:0]                 widx;
    logic [SGW_AW-1:0]                    base_q;
    logic [SGW_WORDS-1:0][SGW_AW-1:0]     words;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            widx   <= '0;
            base_q <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= active && mrd_ack && (widx == LAST_IDX);
            if (go) begin
                active <= 1'b1;
                widx   <= '0;
                base_q <= base;
            end else if (active && mrd_ack) begin
                widx <= widx + 1'b1;
                if (widx == LAST_IDX) begin
                    active <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < SGW_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (active && mrd_ack && (widx == SGW_IDX_W'(g))) begin
                words[g] <= mrd_data;
            end
        end
    end

    assign mrd_req  = active;
    assign mrd_addr = base_q + {{(SGW_AW-SGW_IDX_W-2){1'b0}}, widx, 2'b00};
    assign raw      = words;

endmodule

// File: rtl/sgw_check.sv
module sgw_check
    import sgw_pkg::*;
#(
    parameter int unsigned ALIGN_BITS = 3
) (
    input  sgw_desc_t  desc,
    input  logic       first,
    input  logic       ref_write,
    output logic       fault,
    output sgw_fault_e code
);

    always_comb begin
        fault = 1'b0;
        code  = SGW_OK;
        if (!desc.last && (desc.len == '0)) begin
            fault = 1'b1;
            code  = SGW_ZERO_LEN;
        end else if (!first && (desc.write != ref_write)) begin
            fault = 1'b1;
            code  = SGW_DIR_MISMATCH;
        end else if (!desc.last && !sgw_aligned(desc.next, ALIGN_BITS)) begin
            fault = 1'b1;
            code  = SGW_BAD_PTR;
        end
    end

endmodule

// File: rtl/sgw_issue.sv
module sgw_issue
    import sgw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  sgw_desc_t             desc,
    input  logic                  seg_done,
    output logic                  seg_req,
    output logic [SGW_AW-1:0]     seg_addr,
    output logic [SGW_AW-1:0]     seg_len,
    output logic                  seg_write,
    output logic                  seg_order,
    output logic [SGW_MODE_W-1:0] seg_mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_req   <= 1'b0;
            seg_addr  <= '0;
            seg_len   <= '0;
            seg_write <= 1'b0;
            seg_order <= 1'b0;
            seg_mode  <= '0;
        end else if (load) begin
            seg_req   <= 1'b1;
            seg_addr  <= desc.addr;
            seg_len   <= desc.len;
            seg_write <= desc.write;
            seg_order <= desc.order;
            seg_mode  <= desc.mode;
        end else if (seg_req && seg_done) begin
            seg_req <= 1'b0;
        end
    end

endmodule

// File: rtl/sgw_chain_walker.sv
module sgw_chain_walker
    import sgw_pkg::*;
#(
    parameter int unsigned ALIGN_BITS = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] start_ptr,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [1:0]  err_code,
    output logic        mrd_req,
    output logic [31:0] mrd_addr,
    input  logic        mrd_ack,
    input  logic [31:0] mrd_data,
    output logic        seg_req,
    output logic [31:0] seg_addr,
    output logic [31:0] seg_len,
    output logic        seg_write,
    output logic        seg_order,
    output logic [3:0]  seg_mode,
    input  logic        seg_done
);

    sgw_state_e                   state;
    logic                         first_q;
    logic                         ref_write_q;
    logic                         last_q;
    logic [SGW_AW-1:0]            next_q;
    logic                         done_q;
    logic                         err_q;
    sgw_fault_e                   code_q;

    logic                         fetch_go;
    logic [SGW_AW-1:0]            fetch_base;
    logic [SGW_WORDS*SGW_AW-1:0]  raw;
    logic                         fin;
    sgw_desc_t                    desc;
    logic                         fault;
    sgw_fault_e                   fault_code;
    logic                         issue_load;
    logic                         start_ok;

    assign desc     = sgw_decode(raw);
    assign start_ok = (state == WS_IDLE) && start && sgw_aligned(start_ptr, ALIGN_BITS);

    always_comb begin
        fetch_go   = 1'b0;
        fetch_base = next_q;
        issue_load = 1'b0;
        case (state)
            WS_IDLE: begin
                fetch_go   = start_ok;
                fetch_base = start_ptr;
            end
            WS_FETCH: begin
                issue_load = fin && !fault && !(desc.last && (desc.len == '0));
            end
            WS_ISSUE: begin
                fetch_go = seg_done && !last_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= WS_IDLE;
            first_q     <= 1'b0;
            ref_write_q <= 1'b0;
            last_q      <= 1'b0;
            next_q      <= '0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            code_q      <= SGW_OK;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (start_ok) begin
                        state   <= WS_FETCH;
                        first_q <= 1'b1;
                        code_q  <= SGW_OK;
                    end else if (start) begin
                        err_q  <= 1'b1;
                        code_q <= SGW_BAD_PTR;
                    end
                end
                WS_FETCH: begin
                    if (fin) begin
                        if (fault) begin
                            err_q  <= 1'b1;
                            code_q <= fault_code;
                            state  <= WS_IDLE;
                        end else if (desc.last && (desc.len == '0)) begin
                            done_q <= 1'b1;
                            state  <= WS_IDLE;
                        end else begin
                            if (first_q) begin
                                ref_write_q <= desc.write;
                            end
                            first_q <= 1'b0;
                            last_q  <= desc.last;
                            next_q  <= desc.next;
                            state   <= WS_ISSUE;
                        end
                    end
                end
                WS_ISSUE: begin
                    if (seg_done) begin
                        if (last_q) begin
                            done_q <= 1'b1;
                            state  <= WS_IDLE;
                        end else begin
                            state <= WS_FETCH;
                        end
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    sgw_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .go       (fetch_go),
        .base     (fetch_base),
        .mrd_req  (mrd_req),
        .mrd_addr (mrd_addr),
        .mrd_ack  (mrd_ack),
        .mrd_data (mrd_data),
        .raw      (raw),
        .fin      (fin)
    );

    sgw_check #(.ALIGN_BITS(ALIGN_BITS)) u_check (
        .desc      (desc),
        .first     (first_q),
        .ref_write (ref_write_q),
        .fault     (fault),
        .code      (fault_code)
    );

    sgw_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .load      (issue_load),
        .desc      (desc),
        .seg_done  (seg_done),
        .seg_req   (seg_req),
        .seg_addr  (seg_addr),
        .seg_len   (seg_len),
        .seg_write (seg_write),
        .seg_order (seg_order),
        .seg_mode  (seg_mode)
    );

    assign busy     = (state != WS_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign err_code = code_q;

endmodule

// File: rtl/sgw_chain_walker_sva.sv
module sgw_chain_walker_sva (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [31:0] start_ptr,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [1:0]  err_code,
    input logic        mrd_req,
    input logic [31:0] mrd_addr,
    input logic        mrd_ack,
    input logic [31:0] mrd_data,
    input logic        seg_req,
    input logic [31:0] seg_addr,
    input logic [31:0] seg_len,
    input logic        seg_write,
    input logic        seg_order,
    input logic [3:0]  seg_mode,
    input logic        seg_done
);

    p_mrd_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (mrd_req && !mrd_ack) |=> (mrd_req && $stable(mrd_addr)));

    p_word_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        mrd_req |-> (mrd_addr[1:0] == 2'b00));

    p_seg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (seg_req && !seg_done) |=>
            (seg_req && $stable({seg_addr, seg_len, seg_write, seg_order, seg_mode})));

    p_no_fetch_in_seg_r3: assert property (@(posedge clk) disable iff (rst)
        !(mrd_req && seg_req));

    p_busy_end_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || err));

    p_err_code_r6: assert property (@(posedge clk) disable iff (rst)
        err |-> (err_code != 2'd0));

    p_single_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mrd_req && !seg_req));

endmodule

bind sgw_chain_walker sgw_chain_walker_sva u_sva (.*);

// File: tb/sgw_chain_walker_tb.sv
module sgw_chain_walker_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_ptr = '0;
    logic        busy, done, err;
    logic [1:0]  err_code;
    logic        mrd_req;
    logic [31:0] mrd_addr;
    logic        mrd_ack = 1'b0;
    logic [31:0] mrd_data = '0;
    logic        seg_req;
    logic [31:0] seg_addr, seg_len;
    logic        seg_write, seg_order;
    logic [3:0]  seg_mode;
    logic        seg_done = 1'b0;

    always #4 clk = ~clk;

    sgw_chain_walker u_dut (.*);

    int vecs = 0;
    int fails = 0;
    int cycles = 0;

    logic [31:0] mem [256];
    logic        clr = 1'b0;
    int          rd_n, seg_n, overlap, eng_cnt;
    logic [31:0] rd_log [64];
    logic [69:0] seg_log [16];

    // memory model: one response per request, every other cycle
    always @(negedge clk) begin
        if (mrd_req && !mrd_ack) begin
            mrd_ack  <= 1'b1;
            mrd_data <= mem[mrd_addr[9:2]];
        end else begin
            mrd_ack <= 1'b0;
        end
        if (clr) begin
            rd_n    <= 0;
            overlap <= 0;
        end else begin
            if (mrd_req && !mrd_ack) begin
                if (rd_n < 64) rd_log[rd_n] <= mrd_addr;
                rd_n <= rd_n + 1;
            end
            if (mrd_req && seg_req) overlap <= overlap + 1;
        end
    end

    // transfer engine model with a small varying delay
    always @(negedge clk) begin
        if (clr) begin
            seg_n    <= 0;
            eng_cnt  <= 0;
            seg_done <= 1'b0;
        end else if (seg_req && !seg_done) begin
            if (eng_cnt >= (seg_n % 3)) begin
                seg_done <= 1'b1;
                eng_cnt  <= 0;
                if (seg_n < 16) seg_log[seg_n] <= {seg_addr, seg_len, seg_write, seg_order, seg_mode};
                seg_n <= seg_n + 1;
            end else begin
                eng_cnt <= eng_cnt + 1;
            end
        end else begin
            seg_done <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not end (act %0d cycles, exp < 150000)", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        vecs = vecs + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act %0h exp %0h", req, act, exp);
        end
    endtask

    // expected chain
    logic [31:0] daddr  [8];
    logic [69:0] ex_seg [8];

    task automatic build(input int n, input bit w, input int zl, input int flip, input int bp);
        for (int i = 0; i < n; i++) daddr[i] = 32'd128 + 32'(((i * 5 + n * 3) % 8) * 40);
        for (int i = 0; i < n; i++) begin
            logic [31:0] sa, ln, fl, nx;
            logic        wr, od;
            logic [3:0]  md;
            sa = 32'h1000_0000 + 32'(n * 256) + 32'(i * 64) + 32'(w);
            ln = (i == zl) ? 32'd0 : 32'(i + 1 + n * 2);
            wr = w ^ (i == flip);
            od = i[0];
            md = 4'((n * 4 + i * 3 + int'(w)) % 16);
            fl = {(i[0] ? 16'hA5C3 : 16'h0000), 4'h0, md, (i == n - 1), 1'b0, wr, od, 4'h0};
            nx = (i == n - 1) ? 32'h0000_0301 : daddr[i + 1] + ((i == bp) ? 32'd4 : 32'd0);
            mem[daddr[i][9:2]]        = sa;
            mem[daddr[i][9:2] + 8'd1] = ln;
            mem[daddr[i][9:2] + 8'd2] = fl;
            mem[daddr[i][9:2] + 8'd3] = nx;
            ex_seg[i] = {sa, ln, wr, od, md};
        end
    endtask

    task automatic run(input logic [31:0] ptr, input bit inject,
                       output bit got_done, output bit got_err, output logic [1:0] code);
        got_done = 1'b0;
        got_err  = 1'b0;
        code     = 2'd0;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr       = 1'b0;
        start     = 1'b1;
        start_ptr = ptr;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (inject && k == 6) begin
                start     = 1'b1;
                start_ptr = 32'd8;
            end else begin
                start = 1'b0;
            end
            if (done || err) begin
                got_done = done;
                got_err  = err;
                code     = err_code;
                break;
            end
        end
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic verify(input string req, input int n, input int fault_at,
                          input logic [1:0] exp_code, input int exp_segs, input bit inject);
        bit d, e;
        logic [1:0] c;
        int exp_reads;
        exp_reads = (fault_at >= 0) ? 4 * (fault_at + 1) : 4 * n;
        run(daddr[0], inject, d, e, c);
        chk(d == (fault_at < 0) && e == (fault_at >= 0), req, {d, e}, {fault_at < 0, fault_at >= 0});
        if (fault_at >= 0) chk(c == exp_code, req, c, exp_code);
        chk(!busy, {req, " R4 busy low"}, busy, 0);
        chk(seg_n == exp_segs, {req, " R2 segment count"}, seg_n, exp_segs);
        chk(rd_n == exp_reads, {req, " R1 read count"}, rd_n, exp_reads);
        chk(overlap == 0, {req, " R3 fetch during segment"}, overlap, 0);
        for (int k = 0; k < exp_segs && k < 16; k++)
            chk(seg_log[k] == ex_seg[k], {req, " R2 segment fields"}, seg_log[k], ex_seg[k]);
        for (int k = 0; k < exp_reads && k < 64; k++)
            chk(rd_log[k] == daddr[k / 4] + 32'(4 * (k % 4)), {req, " R1 read address"},
                rd_log[k], daddr[k / 4] + 32'(4 * (k % 4)));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !err && !mrd_req && !seg_req && err_code == 0, "R11 reset state",
            {busy, done, err, mrd_req, seg_req, err_code}, 0);

        // R1 R2 R3 R4: sweep of chain lengths and directions
        for (int n = 1; n <= 4; n++)
            for (int w = 0; w < 2; w++) begin
                build(n, w[0], -1, -1, -1);
                verify("R4 chain walk", n, -1, 2'd0, n, 1'b0);
            end

        // R5: zero-length final entry
        build(2, 1'b0, 1, -1, -1);
        verify("R5 empty final", 2, -1, 2'd0, 1, 1'b0);
        build(1, 1'b1, 0, -1, -1);
        verify("R5 empty single", 1, -1, 2'd0, 0, 1'b0);

        // R6: misaligned next pointer
        build(3, 1'b0, -1, -1, 0);
        verify("R6 bad next", 3, 0, 2'd1, 0, 1'b0);
        build(4, 1'b1, -1, -1, 2);
        verify("R6 bad next late", 4, 2, 2'd1, 2, 1'b0);

        // R7: zero length mid-chain
        build(3, 1'b1, 1, -1, -1);
        verify("R7 zero length", 3, 1, 2'd2, 1, 1'b0);

        // R8: direction mismatch
        build(3, 1'b0, -1, 2, -1);
        verify("R8 direction", 3, 2, 2'd3, 2, 1'b0);
        build(2, 1'b1, -1, 1, -1);
        verify("R8 direction final", 2, 1, 2'd3, 1, 1'b0);

        // R9: priority among simultaneous faults
        build(3, 1'b0, 1, 1, 1);
        verify("R9 priority len", 3, 1, 2'd2, 1, 1'b0);
        build(3, 1'b0, -1, 1, 1);
        verify("R9 priority dir", 3, 1, 2'd3, 1, 1'b0);

        // R10: start while busy
        build(3, 1'b1, -1, -1, -1);
        verify("R10 start ignored", 3, -1, 2'd0, 3, 1'b1);

        // R6: misaligned start pointer, no reads
        begin
            bit d, e;
            logic [1:0] c;
            run(32'h0000_0084, 1'b0, d, e, c);
            chk(e && !d && c == 2'd1, "R6 bad start", {d, e, c}, {1'b0, 1'b1, 2'd1});
            chk(rd_n == 0 && seg_n == 0, "R6 bad start no reads", rd_n, 0);
            chk(c == err_code, "R9 code held", err_code, c);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule